// File: doc/BRIEF.md
# Receive Monitor Descriptor Generator

This block builds the eight-dword descriptors that a receive path posts to a monitor ring. An upstream receive engine hands it one request per MPDU: four opaque MPDU-info dwords, a push reason, an error code, a fragment number and a frameless-BAR flag. The block adds the per-PPDU context it tracks on its own: the PHY PPDU identifier, the address of the PPDU's first status buffer and a running count of status buffers used so far. It then sends the finished descriptor out one 32-bit dword per beat on a valid/ready stream.

PPDU context is captured on a PPDU-start pulse. It is closed by a PPDU-end pulse or a flush pulse. When marker generation is enabled, each close produces a separate end-of-PPDU descriptor. That descriptor carries the closing PPDU's context even if a new PPDU has started before it leaves. A waiting marker always goes out ahead of a waiting MPDU request. A descriptor in flight is never interleaved with another, and is held steady under backpressure.

Top module: `mdg_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `req_ready` is 1.
- R2: Beats go out in the order dword 0 to dword 7, and `out_last` is set only on dword 7. Dword k for k = 0..3 is `req_info[32k+31:32k]`. Dwords 4 and 5 are the low and high halves of the status address captured at the last PPDU start. Dword 7 holds the PPDU ID in [15:0], zero in [19:16] and `ring_tag` in [31:20].
- R3: Dword 6 holds the following fields, with bits [31:17] zero:
  - [1:0] push reason
  - [6:2] error code
  - [10:7] fragment number
  - [11] frameless-BAR flag
  - [15:12] status buffer count
  - [16] end-of-PPDU
- R4: Push reasons are 0 (error), 1 (routed) and 2 (flush). The error code is copied only when the reason is 0; otherwise it is zero.
- R5: The fragment number is copied only when the fragment flag (MPDU-info dword 2, bit 20) is set and the descriptor is not an end-of-PPDU marker; otherwise it is zero.
- R6: For a frameless-BAR request, dwords 0 and 1 are zero. Dword 2 keeps only bits [19:8] (sequence number) and bit 23 (BAR flag). Dword 3 is kept whole, and dword 6 bit 11 is 1.
- R7: Each cycle with `stat_buf_used` high adds one to the status buffer count, which saturates at 15. A PPDU start clears the count to 0, or to 1 if a buffer is used in the same cycle.
- R8: The PPDU ID given with a PPDU start, of any 16-bit value, appears in dword 7 of every later descriptor until the next start.
- R9: With `marker_en` high, a PPDU end or flush queues a marker. The marker has dword 6 bit 16 set, dwords 0-3 zero, and fragment and frameless-BAR fields zero. Its reason is 1 for an end and 2 for a flush. Its count, ID and status address are those at the event, even if a PPDU start follows before the marker is sent.
- R10: With `marker_en` low, PPDU end and flush produce no descriptor, and the next MPDU descriptor is unaffected.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` holds and `out_valid` stays high. `req_ready` is low while a descriptor is being sent.
- R12: A queued marker is sent before any MPDU request that is waiting when the serializer becomes free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| marker_en | input | 1 | Enable end-of-PPDU marker descriptors |
| ppdu_start | input | 1 | PPDU start pulse |
| ppdu_id_in | input | 16 | PHY PPDU ID, sampled on start |
| stat_addr_in | input | 64 | First status buffer address, sampled on start |
| stat_buf_used | input | 1 | One status buffer consumed this cycle |
| ppdu_end | input | 1 | PPDU end pulse |
| ppdu_flush | input | 1 | Flush pulse |
| req_valid | input | 1 | MPDU request present |
| req_ready | output | 1 | MPDU request accepted this cycle if valid |
| req_info | input | 128 | Opaque MPDU-info dwords 0-3 |
| req_reason | input | 2 | Push reason |
| req_err | input | 5 | Error code |
| req_frag | input | 4 | Fragment number |
| req_frameless | input | 1 | Frameless multi-TID BAR entry |
| ring_tag | input | 12 | Ring tag placed in dword 7 [31:20] |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat accepted |
| out_data | output | 32 | Output dword |
| out_last | output | 1 | Last dword of a descriptor |

## Verification
The assertions assume the upstream engine never offers push reason 3. They also assume it never closes a PPDU while an earlier marker is still queued. The stimulus keeps within both limits: reasons are swept over 0 to 2 only, and every end or flush pulse comes after the previous marker has been drained. Event pulses are driven one at a time, away from request handshakes, except in the ordering case. That case deliberately overlaps a busy serializer, a queued marker and a fresh PPDU start.

// File: rtl/mdg_pkg.sv
// Shared types and field positions for the monitor descriptor generator.
// Assumes a fixed eight-dword, 32-bit descriptor layout.
package mdg_pkg;
    localparam int DW       = 32;
    localparam int NDW      = 8;
    localparam int ID_W     = 16;
    localparam int CNT_W    = 4;
    localparam int TAG_W    = 12;
    localparam int ADDR_W   = 64;
    localparam int RSN_W    = 2;
    localparam int ERR_W    = 5;
    localparam int FRAG_W   = 4;
    localparam int INFO_W   = 4 * DW;
    localparam int FRAG_FLAG_BIT = 20;                 // fragment flag in info dword 2
    localparam logic [DW-1:0] BAR_KEEP = 32'h008F_FF00; // seq number and BAR flag

    typedef logic [NDW-1:0][DW-1:0] desc_t;

    typedef enum logic [RSN_W-1:0] {
        RSN_ERROR = 2'd0,
        RSN_ROUTE = 2'd1,
        RSN_FLUSH = 2'd2
    } reason_e;
endpackage

// File: rtl/mdg_ppdu_track.sv
// PPDU context tracker: latches ID and status address at PPDU start,
// counts status buffers with saturation, and snapshots the context into
// a single pending-marker slot on PPDU end or flush.
// Assumes no new close event arrives while a marker is still pending.
module mdg_ppdu_track #(
    parameter int ID_W   = 16,
    parameter int CNT_W  = 4,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ID_W-1:0]   id_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              buf_inc,
    input  logic              end_ev,
    input  logic              flush_ev,
    input  logic              marker_en,
    input  logic              marker_take,
    output logic [ID_W-1:0]   cur_id,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              mk_pend,
    output logic [ID_W-1:0]   mk_id,
    output logic [ADDR_W-1:0] mk_addr,
    output logic [CNT_W-1:0]  mk_cnt,
    output logic              mk_flush
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_step;
    logic             close_ev;

    // Next count value including this cycle's buffer use, saturating.
    always_comb begin
        cnt_step = (buf_inc && cur_cnt != CNT_MAX) ? cur_cnt + CNT_W'(1) : cur_cnt;
        close_ev = (end_ev || flush_ev) && marker_en;
    end

    // Current PPDU context registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_id   <= '0;
            cur_addr <= '0;
            cur_cnt  <= '0;
        end else if (start) begin
            cur_id   <= id_in;
            cur_addr <= addr_in;
            cur_cnt  <= buf_inc ? CNT_W'(1) : '0;
        end else begin
            cur_cnt  <= cnt_step;
        end
    end

    // Pending end-of-PPDU marker snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mk_pend  <= 1'b0;
            mk_id    <= '0;
            mk_addr  <= '0;
            mk_cnt   <= '0;
            mk_flush <= 1'b0;
        end else if (close_ev) begin
            mk_pend  <= 1'b1;
            mk_id    <= cur_id;
            mk_addr  <= cur_addr;
            mk_cnt   <= cnt_step;
            mk_flush <= flush_ev;
        end else if (marker_take) begin
            mk_pend  <= 1'b0;
        end
    end

    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && buf_inc && cur_cnt != CNT_MAX) |=> cur_cnt == CNT_W'($past(cur_cnt) + 1'b1));
    assert_cnt_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && cur_cnt == CNT_MAX) |=> cur_cnt == CNT_MAX);
    assert_id_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> cur_id == $past(id_in));
    assert_single_marker_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mk_pend && !marker_take) |-> !close_ev);
endmodule

// File: rtl/mdg_desc_build.sv
// Combinational descriptor assembly for either an MPDU request or a
// pending end-of-PPDU marker. Applies frameless-BAR masking, error-code
// gating and fragment-number gating.
// Assumes push reason values below 3.
module mdg_desc_build
    import mdg_pkg::*;
(
    input  logic               sel_marker,
    input  logic [INFO_W-1:0]  info,
    input  logic [RSN_W-1:0]   reason,
    input  logic [ERR_W-1:0]   err,
    input  logic [FRAG_W-1:0]  frag,
    input  logic               frameless,
    input  logic [ID_W-1:0]    cur_id,
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [CNT_W-1:0]   cur_cnt,
    input  logic [ID_W-1:0]    mk_id,
    input  logic [ADDR_W-1:0]  mk_addr,
    input  logic [CNT_W-1:0]   mk_cnt,
    input  logic               mk_flush,
    input  logic [TAG_W-1:0]   tag,
    output desc_t              desc
);
    logic [3:0][DW-1:0] mi;
    logic [RSN_W-1:0]   rsn_o;
    logic [ERR_W-1:0]   err_o;
    logic [FRAG_W-1:0]  frag_o;
    logic               fbar_o;
    logic               eop_o;
    logic [CNT_W-1:0]   cnt_o;
    logic [ID_W-1:0]    id_o;
    logic [ADDR_W-1:0]  addr_o;

    // Select source context and mask fields per descriptor kind.
    always_comb begin
        mi = info;
        if (frameless) begin
            mi[0] = '0;
            mi[1] = '0;
            mi[2] = mi[2] & BAR_KEEP;
        end
        if (sel_marker) begin
            mi     = '0;
            rsn_o  = mk_flush ? RSN_FLUSH : RSN_ROUTE;
            err_o  = '0;
            frag_o = '0;
            fbar_o = 1'b0;
            eop_o  = 1'b1;
            cnt_o  = mk_cnt;
            id_o   = mk_id;
            addr_o = mk_addr;
        end else begin
            rsn_o  = reason;
            err_o  = (reason == RSN_ERROR) ? err : '0;
            frag_o = mi[2][FRAG_FLAG_BIT] ? frag : '0;
            fbar_o = frameless;
            eop_o  = 1'b0;
            cnt_o  = cur_cnt;
            id_o   = cur_id;
            addr_o = cur_addr;
        end
    end

    // Pack the eight dwords.
    always_comb begin
        for (int k = 0; k < 4; k++) desc[k] = mi[k];
        desc[4] = addr_o[DW-1:0];
        desc[5] = addr_o[2*DW-1:DW];
        desc[6] = {15'b0, eop_o, cnt_o, fbar_o, frag_o, err_o, rsn_o};
        desc[7] = {tag, 4'b0, id_o};
    end
endmodule

// File: rtl/mdg_beat_ser.sv
// Holds one descriptor and emits it a dword per beat on valid/ready.
// Assumes load is only honoured while idle; a new descriptor never
// overwrites one in flight.
module mdg_beat_ser #(
    parameter int NDW = 8,
    parameter int DW  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [NDW-1:0][DW-1:0]  desc,
    output logic                    busy,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [DW-1:0]           out_data,
    output logic                    out_last
);
    localparam int BEAT_W = $clog2(NDW);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NDW - 1);

    logic [NDW-1:0][DW-1:0] dw_q;
    logic [BEAT_W-1:0]      beat;

    // Load, advance and retire the held descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            beat <= '0;
            dw_q <= '0;
        end else if (!busy) begin
            if (load) begin
                dw_q <= desc;
                busy <= 1'b1;
                beat <= '0;
            end
        end else if (out_ready) begin
            if (beat == LAST_BEAT) busy <= 1'b0;
            else                   beat <= beat + BEAT_W'(1);
        end
    end

    // Output beat selection.
    always_comb begin
        out_valid = busy;
        out_data  = dw_q[beat];
        out_last  = busy && (beat == LAST_BEAT);
    end

    assert_hold_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    assert_gap_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

// File: rtl/mdg_top.sv
// Top of the receive monitor descriptor generator. Arbitrates between a
// pending end-of-PPDU marker and an incoming MPDU request (marker first),
// builds the descriptor and hands it to the beat serializer.
// Assumes the upstream engine never presents push reason 3.
module mdg_top
    import mdg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               marker_en,
    input  logic               ppdu_start,
    input  logic [ID_W-1:0]    ppdu_id_in,
    input  logic [ADDR_W-1:0]  stat_addr_in,
    input  logic               stat_buf_used,
    input  logic               ppdu_end,
    input  logic               ppdu_flush,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [INFO_W-1:0]  req_info,
    input  logic [RSN_W-1:0]   req_reason,
    input  logic [ERR_W-1:0]   req_err,
    input  logic [FRAG_W-1:0]  req_frag,
    input  logic               req_frameless,
    input  logic [TAG_W-1:0]   ring_tag,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DW-1:0]      out_data,
    output logic               out_last
);
    logic [ID_W-1:0]   cur_id, mk_id;
    logic [ADDR_W-1:0] cur_addr, mk_addr;
    logic [CNT_W-1:0]  cur_cnt, mk_cnt;
    logic              mk_pend, mk_flush;
    logic              busy, take_marker, load;
    desc_t             desc;

    // Marker wins over a request whenever the serializer is free.
    always_comb begin
        take_marker = !busy && mk_pend;
        req_ready   = !busy && !mk_pend;
        load        = take_marker || (req_valid && req_ready);
    end

    mdg_ppdu_track #(.ID_W(ID_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_track (
        .clk(clk), .rst_n(rst_n), .start(ppdu_start), .id_in(ppdu_id_in),
        .addr_in(stat_addr_in), .buf_inc(stat_buf_used), .end_ev(ppdu_end),
        .flush_ev(ppdu_flush), .marker_en(marker_en), .marker_take(take_marker),
        .cur_id(cur_id), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
        .mk_pend(mk_pend), .mk_id(mk_id), .mk_addr(mk_addr),
        .mk_cnt(mk_cnt), .mk_flush(mk_flush)
    );

    mdg_desc_build u_build (
        .sel_marker(take_marker), .info(req_info), .reason(req_reason),
        .err(req_err), .frag(req_frag), .frameless(req_frameless),
        .cur_id(cur_id), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
        .mk_id(mk_id), .mk_addr(mk_addr), .mk_cnt(mk_cnt), .mk_flush(mk_flush),
        .tag(ring_tag), .desc(desc)
    );

    mdg_beat_ser #(.NDW(NDW), .DW(DW)) u_ser (
        .clk(clk), .rst_n(rst_n), .load(load), .desc(desc), .busy(busy),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last)
    );

    assert_legal_reason_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (req_reason != 2'd3));
    assert_ready_low_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);
endmodule

// File: tb/mdg_top_tb.sv
module mdg_top_tb;
    import mdg_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic marker_en = 1'b0, ppdu_start = 1'b0, stat_buf_used = 1'b0;
    logic ppdu_end = 1'b0, ppdu_flush = 1'b0, req_valid = 1'b0, out_ready = 1'b0;
    logic req_frameless = 1'b0;
    logic [15:0]  ppdu_id_in = '0;
    logic [63:0]  stat_addr_in = '0;
    logic [127:0] req_info = '0;
    logic [1:0]   req_reason = '0;
    logic [4:0]   req_err = '0;
    logic [3:0]   req_frag = '0;
    logic [11:0]  ring_tag = 12'h5A3;
    logic         req_ready, out_valid, out_last;
    logic [31:0]  out_data;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    logic [15:0] m_id = '0;
    logic [63:0] m_addr = '0;
    int          m_cnt = 0;
    desc_t       mk_exp;

    always #2.5 clk = ~clk;

    mdg_top u_dut (.*);

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            finish_run();
        end
    end

    function automatic desc_t exp_mpdu(input logic [127:0] info, input logic [1:0] rsn,
                                       input logic [4:0] er, input logic [3:0] fn,
                                       input logic fb);
        desc_t d;
        for (int k = 0; k < 4; k++) d[k] = info[32*k +: 32];
        if (fb) begin
            d[0] = '0; d[1] = '0; d[2] = d[2] & 32'h008F_FF00;
        end
        d[4] = m_addr[31:0];
        d[5] = m_addr[63:32];
        d[6] = {15'b0, 1'b0, 4'(m_cnt), fb, (d[2][20] ? fn : 4'd0),
                (rsn == 2'd0 ? er : 5'd0), rsn};
        d[7] = {ring_tag, 4'b0, m_id};
        return d;
    endfunction

    task automatic do_start(input logic [15:0] id, input logic [63:0] addr);
        @(negedge clk); ppdu_start = 1'b1; ppdu_id_in = id; stat_addr_in = addr;
        @(negedge clk); ppdu_start = 1'b0;
        m_id = id; m_addr = addr; m_cnt = 0;
    endtask

    task automatic do_inc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); stat_buf_used = 1'b1;
            @(negedge clk); stat_buf_used = 1'b0;
            if (m_cnt < 15) m_cnt++;
        end
    endtask

    task automatic do_close(input logic fl);
        @(negedge clk); if (fl) ppdu_flush = 1'b1; else ppdu_end = 1'b1;
        mk_exp = '0;
        mk_exp[4] = m_addr[31:0];
        mk_exp[5] = m_addr[63:32];
        mk_exp[6] = {15'b0, 1'b1, 4'(m_cnt), 1'b0, 4'd0, 5'd0, (fl ? 2'd2 : 2'd1)};
        mk_exp[7] = {ring_tag, 4'b0, m_id};
        @(negedge clk); ppdu_flush = 1'b0; ppdu_end = 1'b0;
    endtask

    task automatic send_req(input logic [127:0] info, input logic [1:0] rsn,
                            input logic [4:0] er, input logic [3:0] fn, input logic fb);
        @(negedge clk);
        req_valid = 1'b1; req_info = info; req_reason = rsn;
        req_err = er; req_frag = fn; req_frameless = fb;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk); req_valid = 1'b0;
    endtask

    task automatic recv(input desc_t exp, input int stall, input string r);
        @(negedge clk);
        for (int b = 0; b < 8; b++) begin
            while (!out_valid) @(negedge clk);
            chk(r, out_data, exp[b]);
            chk({r, " last"}, {31'b0, out_last}, {31'b0, (b == 7)});
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                chk({r, " R11 hold"}, out_data, exp[b]);
            end
            out_ready = 1'b1;
            @(posedge clk); #1 out_ready = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [127:0] info;
        desc_t e, ex, ey;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
        chk("R1 req_ready", {31'b0, req_ready}, 32'd1);

        // R2 R3 R4 R5 R6: sweep reasons, error codes, fragment flag, frameless
        do_start(16'hFFFE, 64'h1234_5678_9ABC_DEF0);
        for (int rs = 0; rs < 3; rs++)
            for (int er = 0; er < 32; er++)
                for (int ff = 0; ff < 2; ff++)
                    for (int fb = 0; fb < 2; fb++) begin
                        info = {32'hC0DE_0000 ^ 32'(er), 32'hFF7F_FFFF ^ 32'(rs << 4),
                                32'h89AB_CDEF ^ 32'(er << 3), 32'h0BAD_F00D + 32'(rs)};
                        info[84] = ff[0];
                        e = exp_mpdu(info, 2'(rs), 5'(er), 4'(er + rs), fb[0]);
                        send_req(info, 2'(rs), 5'(er), 4'(er + rs), fb[0]);
                        recv(e, (er + ff) % 3, "R2 R3 R4 R5 R6 mpdu");
                    end

        // R7: status count sweep, saturation, clear on start
        for (int n = 0; n < 19; n += 3) begin
            do_start(16'(n * 4099), 64'(n) << 36);
            do_inc(n);
            info = {4{32'h1111_2222 * 32'(n + 1)}};
            e = exp_mpdu(info, 2'd1, 5'd0, 4'd0, 1'b0);
            chk("R7 model count", e[6][15:12], 32'(n > 15 ? 15 : n));
            send_req(info, 2'd1, 5'd0, 4'd0, 1'b0);
            recv(e, 0, "R7 R8 count/id");
        end

        // R8: ID wrap values
        for (int w = 0; w < 3; w++) begin
            do_start(16'hFFFF + 16'(w), 64'hAAAA);
            info = {4{32'h5555_0000 + 32'(w)}};
            e = exp_mpdu(info, 2'd1, 5'd0, 4'd0, 1'b0);
            send_req(info, 2'd1, 5'd0, 4'd0, 1'b0);
            recv(e, 1, "R8 id wrap");
        end

        // R10: markers disabled
        marker_en = 1'b0;
        do_inc(2);
        do_close(1'b0);
        do_close(1'b1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R10 no marker", {31'b0, out_valid}, 32'd0);
        end
        info = {4{32'h7777_8888}};
        e = exp_mpdu(info, 2'd0, 5'd9, 4'd0, 1'b0);
        send_req(info, 2'd0, 5'd9, 4'd0, 1'b0);
        recv(e, 0, "R10 after ignored close");

        // R9: markers enabled, end and flush
        marker_en = 1'b1;
        do_start(16'h0102, 64'hFEED_0000_BEEF_0000);
        do_inc(4);
        do_close(1'b0);
        recv(mk_exp, 1, "R9 end marker");
        do_inc(20);
        do_close(1'b1);
        recv(mk_exp, 0, "R9 flush marker");

        // R12 R9: marker queued behind busy MPDU, new PPDU starts before it leaves
        do_start(16'h0A0A, 64'h0000_0001_0000_0002);
        do_inc(3);
        info = {4{32'h3C3C_A5A5}};
        ex = exp_mpdu(info, 2'd1, 5'd0, 4'd0, 1'b0);
        send_req(info, 2'd1, 5'd0, 4'd0, 1'b0);
        do_close(1'b0);
        do_start(16'h0B0B, 64'h0000_0003_0000_0004);
        info = {4{32'h6969_1212}};
        ey = exp_mpdu(info, 2'd2, 5'd3, 4'd0, 1'b0);
        fork
            send_req(info, 2'd2, 5'd3, 4'd0, 1'b0);
            begin
                recv(ex, 0, "R12 first mpdu");
                recv(mk_exp, 0, "R12 R9 marker before request");
                recv(ey, 2, "R12 R7 request after marker");
            end
        join

        finish_run();
    end
endmodule